// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block turns a supply-good comparator flag into a system reset, and it also watches the software through a watchdog. While the supply flag is low, reset is asserted at once, without waiting for a clock edge. Once the flag goes high, reset is held for a power-on hold time and then released. Two configuration bits pick the hold time from four table entries.

After release, a watchdog counts clock edges. The count restarts on each kick strobe. If the count reaches the interval chosen by two more configuration bits, the block raises a watchdog flag and re-enters the reset hold for the same hold time as at power-on. One of the watchdog codes turns the watchdog off.

All durations are parameters given in clock ticks. A simulation can therefore use short counts, while a real chip sets values that match its clock rate.

Top module: `sup_top`

## Requirements
- R1: While `supplyOk` is low, `rstOut` is 1 and `wdogFlag` is 0, and this takes effect asynchronously, without waiting for a clock edge.
- R2: After `supplyOk` rises, `rstOut` stays 1 for exactly the selected hold count of rising clock edges, counted from the first edge with `supplyOk` high, and is 0 after that edge.
- R3: `holdSel` codes 00, 01, 10 and 11 select the hold counts `HOLD0`, `HOLD1`, `HOLD2` and `HOLD3`.
- R4: `rstOutN` is always the inverse of `rstOut`.
- R5: With no kick, the watchdog expires on the N-th rising edge after the release edge. `wdogSel` codes 00, 01 and 10 select N as `WDOG0`, `WDOG1` and `WDOG2`.
- R6: With `wdogSel` = 11, the watchdog never expires, so reset stays 0 and `wdogFlag` stays 0.
- R7: A kick sampled high at a rising edge restarts the interval. The next expiry falls on the N-th edge after that kick edge.
- R8: On expiry, `wdogFlag` and `rstOut` both go to 1 on the same edge. Reset is then held for the hold count chosen by `holdSel`, then released, and the watchdog restarts.
- R9: `wdogFlag` stays 1 until a kick is sampled at a rising edge or `supplyOk` goes low. A sampled kick clears it on that edge, in any state.
- R10: While reset is asserted, the watchdog count is held at zero. Kicks during the hold do not shorten the first interval after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supplyOk | input | 1 | Supply-good comparator flag, low means the supply is below its threshold |
| kick | input | 1 | Watchdog restart strobe, sampled on rising edges |
| holdSel | input | 2 | Power-on hold time select |
| wdogSel | input | 2 | Watchdog interval select, 11 disables the watchdog |
| rstOut | output | 1 | Reset, active high |
| rstOutN | output | 1 | Reset, active low |
| wdogFlag | output | 1 | Watchdog expiry indicator |

## Verification
Two results have no latency at all. The effect of `supplyOk` falling is checked one nanosecond after the drop, and the `rstOutN` inverse holds at every instant. Every other result lands on a rising edge and is registered once:
- Release comes on the edge that completes the hold count.
- Expiry and the flag rise come on the edge that completes the interval.
- A kick clears the flag on the edge that samples it.

The bench drives inputs two nanoseconds after a rising edge and compares all outputs with its model at the following falling edge. Durations are measured by counting falling edges at a given reset level. The rules above make that count exactly equal to the selected tick value.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic holdClr;
    logic holdInc;
    logic wdClr;
    logic wdInc;
  } supStrobe_t;

  localparam logic [1:0] WD_DISABLED = 2'b11;

  function automatic int unsigned maxOf2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_tick_counter.sv
module sup_tick_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count != {WIDTH{1'b1}})) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sup_dpath.sv
module sup_dpath
  import sup_pkg::*;
#(
  parameter int unsigned HOLD0 = 50,
  parameter int unsigned HOLD1 = 200,
  parameter int unsigned HOLD2 = 400,
  parameter int unsigned HOLD3 = 800,
  parameter int unsigned WDOG0 = 25,
  parameter int unsigned WDOG1 = 200,
  parameter int unsigned WDOG2 = 1400
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic [1:0] holdSel,
  input  logic [1:0] wdogSel,
  input  supStrobe_t strobes,
  output logic       holdDone,
  output logic       wdExpire
);

  localparam int unsigned HOLD_MAX = maxOf2(maxOf2(HOLD0, HOLD1), maxOf2(HOLD2, HOLD3));
  localparam int unsigned WDOG_MAX = maxOf2(maxOf2(WDOG0, WDOG1), WDOG2);
  localparam int HW = $clog2(HOLD_MAX + 1);
  localparam int WW = $clog2(WDOG_MAX + 1);

  logic [HW-1:0] holdCount;
  logic [HW-1:0] holdLast;
  logic [WW-1:0] wdCount;
  logic [WW-1:0] wdLast;

  sup_tick_counter #(.WIDTH(HW)) holdCtr (
    .clk   (clk),
    .arstN (supplyOk),
    .clr   (strobes.holdClr),
    .inc   (strobes.holdInc),
    .count (holdCount)
  );

  sup_tick_counter #(.WIDTH(WW)) wdCtr (
    .clk   (clk),
    .arstN (supplyOk),
    .clr   (strobes.wdClr),
    .inc   (strobes.wdInc),
    .count (wdCount)
  );

  // Last count value before the selected duration completes
  always_comb begin
    case (holdSel)
      2'b00:   holdLast = HW'(HOLD0 - 1);
      2'b01:   holdLast = HW'(HOLD1 - 1);
      2'b10:   holdLast = HW'(HOLD2 - 1);
      default: holdLast = HW'(HOLD3 - 1);
    endcase
  end

  always_comb begin
    case (wdogSel)
      2'b00:   wdLast = WW'(WDOG0 - 1);
      2'b01:   wdLast = WW'(WDOG1 - 1);
      default: wdLast = WW'(WDOG2 - 1);
    endcase
  end

  // Greater-or-equal tolerates a select change mid-count
  assign holdDone = (holdCount >= holdLast);
  assign wdExpire = (wdogSel != WD_DISABLED) && (wdCount >= wdLast);

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       kick,
  input  logic [1:0] wdogSel,
  input  logic       holdDone,
  input  logic       wdExpire,
  output supStrobe_t strobes,
  output logic       inReset,
  output logic       wdogFlag
);

  logic inResetNext;
  logic flagNext;

  always_comb begin
    strobes     = '0;
    inResetNext = inReset;
    flagNext    = wdogFlag;
    if (kick) begin
      flagNext = 1'b0;
    end
    if (inReset) begin
      strobes.wdClr = 1'b1;
      if (holdDone) begin
        strobes.holdClr = 1'b1;
        inResetNext     = 1'b0;
      end else begin
        strobes.holdInc = 1'b1;
      end
    end else begin
      strobes.holdClr = 1'b1;
      if (kick || (wdogSel == WD_DISABLED)) begin
        strobes.wdClr = 1'b1;
      end else if (wdExpire) begin
        strobes.wdClr = 1'b1;
        inResetNext   = 1'b1;
        flagNext      = 1'b1;
      end else begin
        strobes.wdInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      inReset  <= 1'b1;
      wdogFlag <= 1'b0;
    end else begin
      inReset  <= inResetNext;
      wdogFlag <= flagNext;
    end
  end

endmodule

// File: rtl/sup_top.sv
module sup_top
  import sup_pkg::*;
#(
  parameter int unsigned HOLD0 = 50,
  parameter int unsigned HOLD1 = 200,
  parameter int unsigned HOLD2 = 400,
  parameter int unsigned HOLD3 = 800,
  parameter int unsigned WDOG0 = 25,
  parameter int unsigned WDOG1 = 200,
  parameter int unsigned WDOG2 = 1400
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       kick,
  input  logic [1:0] holdSel,
  input  logic [1:0] wdogSel,
  output logic       rstOut,
  output logic       rstOutN,
  output logic       wdogFlag
);

  supStrobe_t strobes;
  logic       holdDone;
  logic       wdExpire;
  logic       inReset;

  sup_ctrl ctrl (
    .clk      (clk),
    .supplyOk (supplyOk),
    .kick     (kick),
    .wdogSel  (wdogSel),
    .holdDone (holdDone),
    .wdExpire (wdExpire),
    .strobes  (strobes),
    .inReset  (inReset),
    .wdogFlag (wdogFlag)
  );

  sup_dpath #(
    .HOLD0 (HOLD0), .HOLD1 (HOLD1), .HOLD2 (HOLD2), .HOLD3 (HOLD3),
    .WDOG0 (WDOG0), .WDOG1 (WDOG1), .WDOG2 (WDOG2)
  ) dpath (
    .clk      (clk),
    .supplyOk (supplyOk),
    .holdSel  (holdSel),
    .wdogSel  (wdogSel),
    .strobes  (strobes),
    .holdDone (holdDone),
    .wdExpire (wdExpire)
  );

  assign rstOut  = inReset;
  assign rstOutN = ~inReset;

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic       clk,
  input logic       supplyOk,
  input logic       kick,
  input logic [1:0] holdSel,
  input logic [1:0] wdogSel,
  input logic       rstOut,
  input logic       rstOutN,
  input logic       wdogFlag
);

  // R1: low supply forces reset and clears the flag
  always @(negedge clk) begin
    if (supplyOk === 1'b0) begin
      p_low_supply_r1: assert (rstOut === 1'b1 && wdogFlag === 1'b0);
    end
  end

  p_complement_r4: assert property (@(posedge clk) disable iff (!supplyOk)
    rstOutN == !rstOut);

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!supplyOk)
    (wdogSel == 2'b11 && !wdogFlag) |=> !wdogFlag);

  p_flag_with_reset_r8: assert property (@(posedge clk) disable iff (!supplyOk)
    $rose(wdogFlag) |-> rstOut);

  p_reentry_flagged_r8: assert property (@(posedge clk) disable iff (!supplyOk)
    $rose(rstOut) |-> wdogFlag);

  p_kick_clears_r9: assert property (@(posedge clk) disable iff (!supplyOk)
    kick |=> !wdogFlag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!supplyOk)
    (wdogFlag && !kick) |=> wdogFlag);

endmodule

bind sup_top sup_checker chk (.*);

// File: tb/sup_top_test.sv
module sup_top_test;

  localparam int HT [4] = '{6, 11, 17, 23};
  localparam int WT [3] = '{9, 14, 20};

  logic       clk = 1'b0;
  logic       supplyOk = 1'b0;
  logic       kick = 1'b0;
  logic [1:0] holdSel = 2'b00;
  logic [1:0] wdogSel = 2'b11;
  logic       rstOut, rstOutN, wdogFlag;

  int    nChecks = 0;
  int    nFail = 0;
  string phase = "R1";

  sup_top #(
    .HOLD0(HT[0]), .HOLD1(HT[1]), .HOLD2(HT[2]), .HOLD3(HT[3]),
    .WDOG0(WT[0]), .WDOG1(WT[1]), .WDOG2(WT[2])
  ) uut (
    .clk(clk), .supplyOk(supplyOk), .kick(kick), .holdSel(holdSel),
    .wdogSel(wdogSel), .rstOut(rstOut), .rstOutN(rstOutN), .wdogFlag(wdogFlag)
  );

  always #5 clk = ~clk;

  // Behavioural reference: elapsed-edge counters
  bit mRst = 1'b1;
  bit mFlag = 1'b0;
  int mHoldAge = 0;
  int mIdle = 0;

  always @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      mRst = 1'b1; mFlag = 1'b0; mHoldAge = 0; mIdle = 0;
    end else if (mRst) begin
      if (kick) mFlag = 1'b0;
      mIdle = 0;
      mHoldAge++;
      if (mHoldAge >= HT[holdSel]) begin
        mRst = 1'b0; mHoldAge = 0;
      end
    end else if (wdogSel == 2'b11 || kick) begin
      mIdle = 0;
      if (kick) mFlag = 1'b0;
    end else begin
      mIdle++;
      if (mIdle >= WT[wdogSel]) begin
        mIdle = 0; mRst = 1'b1; mHoldAge = 0; mFlag = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(rstOut === mRst, {phase, " rstOut"}, int'(rstOut), int'(mRst));
    check(rstOutN === !mRst, "R4 rstOutN", int'(rstOutN), int'(!mRst));
    check(wdogFlag === mFlag, {phase, " wdogFlag"}, int'(wdogFlag), int'(mFlag));
  end

  task automatic countWhile(input logic lvl, output int n);
    n = 0;
    while (rstOut === lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int n, m, h;
    repeat (3) @(posedge clk);
    #2;
    check(rstOut === 1'b1, "R1 reset while supply low", int'(rstOut), 1);
    check(wdogFlag === 1'b0, "R1 flag while supply low", int'(wdogFlag), 0);

    // R2 / R3: every hold code
    for (int s = 0; s < 4; s++) begin
      phase = "R2";
      @(posedge clk); #2;
      holdSel = 2'(s); wdogSel = 2'b11; supplyOk = 1'b1;
      @(negedge clk);
      countWhile(1'b1, n);
      check(n == HT[s], "R3 hold length per code", n, HT[s]);
      @(posedge clk); #2;
      supplyOk = 1'b0;
      #1;
      check(rstOut === 1'b1, "R1 immediate assert", int'(rstOut), 1);
      check(rstOutN === 1'b0, "R4 low output follows", int'(rstOutN), 0);
    end

    // R6: disabled watchdog
    phase = "R6";
    @(posedge clk); #2;
    holdSel = 2'b00; wdogSel = 2'b11; supplyOk = 1'b1;
    @(negedge clk);
    countWhile(1'b1, n);
    m = 0;
    repeat (3 * WT[2]) begin
      @(negedge clk);
      if (rstOut !== 1'b0 || wdogFlag !== 1'b0) m++;
    end
    check(m == 0, "R6 no expiry when disabled", m, 0);

    // R5 / R8 / R9: each interval code
    for (int w = 0; w < 3; w++) begin
      phase = "R5";
      @(posedge clk); #2;
      supplyOk = 1'b0;
      @(posedge clk); #2;
      wdogSel = 2'(w); holdSel = 2'(w); supplyOk = 1'b1;
      @(negedge clk);
      countWhile(1'b1, n);
      countWhile(1'b0, m);
      check(m == WT[w], "R5 interval per code", m, WT[w]);
      check(wdogFlag === 1'b1, "R8 flag on expiry", int'(wdogFlag), 1);
      phase = "R8";
      countWhile(1'b1, h);
      check(h == HT[w], "R8 hold after expiry", h, HT[w]);
      phase = "R9";
      check(wdogFlag === 1'b1, "R9 flag kept after release", int'(wdogFlag), 1);
      @(posedge clk); #2; kick = 1'b1;
      @(posedge clk); #2; kick = 1'b0;
      @(negedge clk);
      check(wdogFlag === 1'b0, "R9 kick clears flag", int'(wdogFlag), 0);
    end

    // R7: regular kicks keep reset off; expiry measured from last kick
    phase = "R7";
    m = 0;
    repeat (6) begin
      @(posedge clk); #2; kick = 1'b1;
      @(posedge clk); #2; kick = 1'b0;
      repeat (WT[2] - 3) begin
        @(negedge clk);
        if (rstOut !== 1'b0) m++;
      end
    end
    check(m == 0, "R7 kicks prevent expiry", m, 0);
    @(posedge clk); #2; kick = 1'b1;
    @(posedge clk); #2; kick = 1'b0;
    @(negedge clk);
    countWhile(1'b0, n);
    check(n == WT[2], "R7 interval from last kick", n, WT[2]);

    // R10: kicks during hold do not pre-load the interval
    phase = "R10";
    repeat (4) begin
      @(posedge clk); #2; kick = 1'b1;
      @(posedge clk); #2; kick = 1'b0;
    end
    @(negedge clk);
    check(wdogFlag === 1'b0, "R9 kick in hold clears flag", int'(wdogFlag), 0);
    countWhile(1'b1, h);
    countWhile(1'b0, n);
    check(n == WT[2], "R10 full interval after hold", n, WT[2]);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule